// File: doc/BRIEF.md
# Mixed-Width True Dual-Port Memory

This block is a two-port synchronous memory holding 16K data bits and 2K parity bits. Both ports see the same storage, but each port picks its own word width when the block is elaborated. A narrow port and a wide port can therefore write and read the same bits through different word sizes. Widths of 9 and 18 carry a parity part next to the data part. The parity bits sit in their own shared array, and each parity bit is tied to one data byte.

Each port has an enable, a write enable, a 14-bit address, data and parity inputs, and registered data and parity outputs. A per-port mode parameter sets what the registered output shows on a write cycle: the new word, the old word, or an unchanged value. Both ports run on one clock. The output registers clear on a synchronous active-high reset. The stored contents are left as they are.

Top module: `dp_ratio_ram`

## Requirements
- R1: While `rst` is high at a clock edge, both data outputs and both parity outputs are 0 after that edge.
- R2: `WIDTH_x` sets a port's word size, and only 1, 2, 4, 9 and 18 are allowed. Let D be the data width (1, 2, 4, 8, 16), P the parity width (0, 0, 0, 1, 2) and k = log2(D). A read (`en`=1, `we`=0) at an edge puts shared data bits [(addr>>k)*D +: D] and parity bits [(addr>>k)*P +: P] on the outputs after that edge. The low k address bits are ignored.
- R3: Both ports address one data array and one parity array with the numbering of R2, so a word written at one width reads back at any other width. A read on one port while the other port writes the same bits on the same edge returns the contents from before that edge.
- R4: In mode 0 (new-data), a write cycle puts the written data and parity words on the writing port's outputs.
- R5: In mode 1 (old-data), a write cycle puts the contents from before the write on the writing port's outputs.
- R6: In mode 2 (hold), a write cycle leaves the writing port's outputs unchanged.
- R7: With `en` low, a port neither reads nor writes, and its outputs hold their values.
- R8: For widths 1, 2 and 4 the parity ports are one bit wide, the parity input is ignored, and the parity output stays 0.
- R9: A write changes only the D data bits and P parity bits it addresses. This still holds when both ports write different bits of the same 16-bit storage row on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high clear of the output registers |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | ADDR_W | Port A bit-granular address |
| a_din | input | DW_A | Port A write data |
| a_pin | input | PPW_A | Port A write parity (ignored without parity) |
| a_dout | output | DW_A | Port A registered read data |
| a_pout | output | PPW_A | Port A registered read parity |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | ADDR_W | Port B bit-granular address |
| b_din | input | DW_B | Port B write data |
| b_pin | input | PPW_B | Port B write parity (ignored without parity) |
| b_dout | output | DW_B | Port B registered read data |
| b_pout | output | PPW_B | Port B registered read parity |

## Verification
The bench builds 25 copies of the block, one for every ordered pair of widths from {1, 2, 4, 9, 18}. Each copy uses the default 14-bit address and 16-bit rows. The write modes rotate across the copies, so every mode runs on both ports against every width on the other side. Each copy first fills the whole array through its wider port, so every bit has a known value. It then sends mixed traffic mostly into a 96-bit window. Narrow and wide words land in the same rows there, which brings cross-width aliasing, same-row writes from both ports and reads during the other port's writes within reach.

// File: rtl/ratio_pkg.sv
package ratio_pkg;

  // write-cycle output behaviour, per port
  localparam int MODE_WF = 0;  // show written word
  localparam int MODE_RF = 1;  // show previous contents
  localparam int MODE_NC = 2;  // keep output unchanged

  // data bits of a port of the given total width
  function automatic int data_w(input int w);
    return (w >= 9) ? (w / 9) * 8 : w;
  endfunction

  // parity bits of a port of the given total width
  function automatic int par_w(input int w);
    return (w >= 9) ? (w / 9) : 0;
  endfunction

  // parity pin width (at least one bit so the port exists)
  function automatic int par_pin_w(input int w);
    return (par_w(w) == 0) ? 1 : par_w(w);
  endfunction

  // low address bits a port ignores
  function automatic int low_skip(input int w);
    return $clog2(data_w(w));
  endfunction

endpackage

// File: rtl/ratio_port_map.sv
// Maps one port's address and data onto a storage row: row index,
// masks and aligned values for writes, extraction for reads.
module ratio_port_map #(
  parameter int WIDTH  = 9,
  parameter int ADDR_W = 14,
  parameter int ROW_W  = 16,
  localparam int DW      = ratio_pkg::data_w(WIDTH),
  localparam int PW      = ratio_pkg::par_w(WIDTH),
  localparam int PPW     = ratio_pkg::par_pin_w(WIDTH),
  localparam int K       = ratio_pkg::low_skip(WIDTH),
  localparam int ROW_LG  = $clog2(ROW_W),
  localparam int PROW_W  = ROW_W / 8,
  localparam int PROW_LG = (PROW_W > 1) ? $clog2(PROW_W) : 1,
  localparam int RAW     = ADDR_W - ROW_LG
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     din,
  input  logic [PPW-1:0]    pin,
  input  logic [ROW_W-1:0]  drow,
  input  logic [PROW_W-1:0] prow,
  output logic [RAW-1:0]    row,
  output logic [ROW_W-1:0]  dmask,
  output logic [ROW_W-1:0]  dval,
  output logic [PROW_W-1:0] pmask,
  output logic [PROW_W-1:0] pval,
  output logic [DW-1:0]     rd_d,
  output logic [PPW-1:0]    rd_p,
  output logic [PPW-1:0]    wr_p
);

  // clears the address bits below the word boundary
  localparam logic [ROW_LG-1:0] KEEP = ROW_LG'((1 << ROW_LG) - (1 << K));

  logic [ROW_LG-1:0] off;

  assign row   = addr[ADDR_W-1:ROW_LG];
  assign off   = addr[ROW_LG-1:0] & KEEP;
  assign dmask = ROW_W'({DW{1'b1}}) << off;
  assign dval  = ROW_W'(din) << off;
  assign rd_d  = DW'(drow >> off);

  generate
    if (PW > 0) begin : g_par
      logic [PROW_LG-1:0] poff;
      assign poff  = PROW_LG'(off >> 3);
      assign pmask = PROW_W'({PW{1'b1}}) << poff;
      assign pval  = PROW_W'(pin) << poff;
      assign rd_p  = PPW'(prow >> poff);
      assign wr_p  = pin;
    end else begin : g_nopar
      logic unused_par;
      assign unused_par = ^{pin, prow};
      assign pmask = '0;
      assign pval  = '0;
      assign rd_p  = '0;
      assign wr_p  = '0;
    end
  endgenerate

endmodule

// File: rtl/ratio_store.sv
// Shared row storage for data and parity. Two ports may write different
// bits of the same row on one edge; port B's update is built on top of
// port A's so neither change is lost.
module ratio_store #(
  parameter int ROW_W  = 16,
  parameter int RAW    = 10,
  parameter int PROW_W = 2,
  localparam int ROWS  = 1 << RAW
) (
  input  logic              clk,
  input  logic              a_wr,
  input  logic [RAW-1:0]    a_row,
  input  logic [ROW_W-1:0]  a_dmask,
  input  logic [ROW_W-1:0]  a_dval,
  input  logic [PROW_W-1:0] a_pmask,
  input  logic [PROW_W-1:0] a_pval,
  input  logic              b_wr,
  input  logic [RAW-1:0]    b_row,
  input  logic [ROW_W-1:0]  b_dmask,
  input  logic [ROW_W-1:0]  b_dval,
  input  logic [PROW_W-1:0] b_pmask,
  input  logic [PROW_W-1:0] b_pval,
  output logic [ROW_W-1:0]  a_drow,
  output logic [PROW_W-1:0] a_prow,
  output logic [ROW_W-1:0]  b_drow,
  output logic [PROW_W-1:0] b_prow
);

  logic [ROW_W-1:0]  dmem [ROWS];
  logic [PROW_W-1:0] pmem [ROWS];

  logic [ROW_W-1:0]  a_dnew, b_dbase, b_dnew;
  logic [PROW_W-1:0] a_pnew, b_pbase, b_pnew;
  logic              same_row;

  assign a_drow = dmem[a_row];
  assign a_prow = pmem[a_row];
  assign b_drow = dmem[b_row];
  assign b_prow = pmem[b_row];

  assign same_row = a_wr && (a_row == b_row);

  always_comb begin
    a_dnew  = (a_drow & ~a_dmask) | a_dval;
    a_pnew  = (a_prow & ~a_pmask) | a_pval;
    b_dbase = same_row ? a_dnew : b_drow;
    b_pbase = same_row ? a_pnew : b_prow;
    b_dnew  = (b_dbase & ~b_dmask) | b_dval;
    b_pnew  = (b_pbase & ~b_pmask) | b_pval;
  end

  always_ff @(posedge clk) begin
    if (a_wr) begin
      dmem[a_row] <= a_dnew;
      pmem[a_row] <= a_pnew;
    end
    if (b_wr) begin
      dmem[b_row] <= b_dnew;
      pmem[b_row] <= b_pnew;
    end
  end

endmodule

// File: rtl/ratio_port_out.sv
// Registered output of one port; MODE picks what a write cycle shows.
module ratio_port_out #(
  parameter int DW   = 8,
  parameter int PPW  = 1,
  parameter int MODE = ratio_pkg::MODE_WF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           we,
  input  logic [DW-1:0]  wr_d,
  input  logic [PPW-1:0] wr_p,
  input  logic [DW-1:0]  rd_d,
  input  logic [PPW-1:0] rd_p,
  output logic [DW-1:0]  dout,
  output logic [PPW-1:0] pout
);

  logic [DW-1:0]  wv_d;
  logic [PPW-1:0] wv_p;
  logic           upd;

  generate
    if (MODE == ratio_pkg::MODE_WF) begin : g_new
      assign wv_d = wr_d;
      assign wv_p = wr_p;
    end else begin : g_old
      logic unused_wr;
      assign unused_wr = ^{wr_d, wr_p};
      assign wv_d = rd_d;
      assign wv_p = rd_p;
    end
  endgenerate

  assign upd = en && (!we || (MODE != ratio_pkg::MODE_NC));

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      pout <= '0;
    end else if (upd) begin
      dout <= we ? wv_d : rd_d;
      pout <= we ? wv_p : rd_p;
    end
  end

endmodule

// File: rtl/dp_ratio_ram.sv
module dp_ratio_ram #(
  parameter int WIDTH_A = 9,
  parameter int WIDTH_B = 18,
  parameter int MODE_A  = ratio_pkg::MODE_WF,
  parameter int MODE_B  = ratio_pkg::MODE_NC,
  parameter int ADDR_W  = 14,
  parameter int ROW_W   = 16,
  localparam int DW_A   = ratio_pkg::data_w(WIDTH_A),
  localparam int DW_B   = ratio_pkg::data_w(WIDTH_B),
  localparam int PPW_A  = ratio_pkg::par_pin_w(WIDTH_A),
  localparam int PPW_B  = ratio_pkg::par_pin_w(WIDTH_B),
  localparam int PROW_W = ROW_W / 8,
  localparam int RAW    = ADDR_W - $clog2(ROW_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DW_A-1:0]   a_din,
  input  logic [PPW_A-1:0]  a_pin,
  output logic [DW_A-1:0]   a_dout,
  output logic [PPW_A-1:0]  a_pout,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DW_B-1:0]   b_din,
  input  logic [PPW_B-1:0]  b_pin,
  output logic [DW_B-1:0]   b_dout,
  output logic [PPW_B-1:0]  b_pout
);

  logic [RAW-1:0]    a_row, b_row;
  logic [ROW_W-1:0]  a_dmask, a_dval, b_dmask, b_dval, a_drow, b_drow;
  logic [PROW_W-1:0] a_pmask, a_pval, b_pmask, b_pval, a_prow, b_prow;
  logic [DW_A-1:0]   a_rd_d;
  logic [DW_B-1:0]   b_rd_d;
  logic [PPW_A-1:0]  a_rd_p, a_wr_p;
  logic [PPW_B-1:0]  b_rd_p, b_wr_p;
  logic              a_wr, b_wr;

  assign a_wr = a_en && a_we;
  assign b_wr = b_en && b_we;

  ratio_port_map #(.WIDTH(WIDTH_A), .ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_map_a (
    .addr(a_addr), .din(a_din), .pin(a_pin), .drow(a_drow), .prow(a_prow),
    .row(a_row), .dmask(a_dmask), .dval(a_dval), .pmask(a_pmask),
    .pval(a_pval), .rd_d(a_rd_d), .rd_p(a_rd_p), .wr_p(a_wr_p)
  );

  ratio_port_map #(.WIDTH(WIDTH_B), .ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_map_b (
    .addr(b_addr), .din(b_din), .pin(b_pin), .drow(b_drow), .prow(b_prow),
    .row(b_row), .dmask(b_dmask), .dval(b_dval), .pmask(b_pmask),
    .pval(b_pval), .rd_d(b_rd_d), .rd_p(b_rd_p), .wr_p(b_wr_p)
  );

  ratio_store #(.ROW_W(ROW_W), .RAW(RAW), .PROW_W(PROW_W)) u_store (
    .clk(clk),
    .a_wr(a_wr), .a_row(a_row), .a_dmask(a_dmask), .a_dval(a_dval),
    .a_pmask(a_pmask), .a_pval(a_pval),
    .b_wr(b_wr), .b_row(b_row), .b_dmask(b_dmask), .b_dval(b_dval),
    .b_pmask(b_pmask), .b_pval(b_pval),
    .a_drow(a_drow), .a_prow(a_prow), .b_drow(b_drow), .b_prow(b_prow)
  );

  ratio_port_out #(.DW(DW_A), .PPW(PPW_A), .MODE(MODE_A)) u_out_a (
    .clk(clk), .rst(rst), .en(a_en), .we(a_we), .wr_d(a_din), .wr_p(a_wr_p),
    .rd_d(a_rd_d), .rd_p(a_rd_p), .dout(a_dout), .pout(a_pout)
  );

  ratio_port_out #(.DW(DW_B), .PPW(PPW_B), .MODE(MODE_B)) u_out_b (
    .clk(clk), .rst(rst), .en(b_en), .we(b_we), .wr_d(b_din), .wr_p(b_wr_p),
    .rd_d(b_rd_d), .rd_p(b_rd_p), .dout(b_dout), .pout(b_pout)
  );

endmodule

// File: rtl/dp_ratio_ram_chk.sv
module dp_ratio_ram_chk #(
  parameter int WIDTH_A = 9,
  parameter int WIDTH_B = 18,
  parameter int MODE_A  = 0,
  parameter int MODE_B  = 2,
  parameter int ADDR_W  = 14,
  localparam int DW_A   = ratio_pkg::data_w(WIDTH_A),
  localparam int DW_B   = ratio_pkg::data_w(WIDTH_B),
  localparam int PW_A   = ratio_pkg::par_w(WIDTH_A),
  localparam int PW_B   = ratio_pkg::par_w(WIDTH_B),
  localparam int PPW_A  = ratio_pkg::par_pin_w(WIDTH_A),
  localparam int PPW_B  = ratio_pkg::par_pin_w(WIDTH_B)
) (
  input logic              clk,
  input logic              rst,
  input logic              a_en,
  input logic              a_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DW_A-1:0]   a_din,
  input logic [PPW_A-1:0]  a_pin,
  input logic [DW_A-1:0]   a_dout,
  input logic [PPW_A-1:0]  a_pout,
  input logic              b_en,
  input logic              b_we,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DW_B-1:0]   b_din,
  input logic [PPW_B-1:0]  b_pin,
  input logic [DW_B-1:0]   b_dout,
  input logic [PPW_B-1:0]  b_pout
);

  logic unused_chk;
  assign unused_chk = ^{a_addr, b_addr};

  assert_rst_clear_a_R1: assert property (@(posedge clk)
    rst |=> (a_dout == '0 && a_pout == '0));
  assert_rst_clear_b_R1: assert property (@(posedge clk)
    rst |=> (b_dout == '0 && b_pout == '0));

  assert_idle_hold_a_R7: assert property (@(posedge clk) disable iff (rst)
    !a_en |=> ($stable(a_dout) && $stable(a_pout)));
  assert_idle_hold_b_R7: assert property (@(posedge clk) disable iff (rst)
    !b_en |=> ($stable(b_dout) && $stable(b_pout)));

  generate
    if (MODE_A == ratio_pkg::MODE_WF) begin : g_wf_a
      assert_new_data_a_R4: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_we) |=> (a_dout == $past(a_din)));
    end
    if (MODE_B == ratio_pkg::MODE_WF) begin : g_wf_b
      assert_new_data_b_R4: assert property (@(posedge clk) disable iff (rst)
        (b_en && b_we) |=> (b_dout == $past(b_din)));
    end
    if (MODE_A == ratio_pkg::MODE_NC) begin : g_nc_a
      assert_hold_on_write_a_R6: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_we) |=> ($stable(a_dout) && $stable(a_pout)));
    end
    if (MODE_B == ratio_pkg::MODE_NC) begin : g_nc_b
      assert_hold_on_write_b_R6: assert property (@(posedge clk) disable iff (rst)
        (b_en && b_we) |=> ($stable(b_dout) && $stable(b_pout)));
    end
    if (PW_A == 0) begin : g_np_a
      logic unused_pa;
      assign unused_pa = ^a_pin;
      assert_no_parity_a_R8: assert property (@(posedge clk) disable iff (rst)
        a_pout == '0);
    end
    if (PW_B == 0) begin : g_np_b
      logic unused_pb;
      assign unused_pb = ^b_pin;
      assert_no_parity_b_R8: assert property (@(posedge clk) disable iff (rst)
        b_pout == '0);
    end
  endgenerate

endmodule

bind dp_ratio_ram dp_ratio_ram_chk #(
  .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B), .MODE_A(MODE_A), .MODE_B(MODE_B),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst),
  .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
  .a_dout(a_dout), .a_pout(a_pout),
  .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
  .b_dout(b_dout), .b_pout(b_pout)
);

// File: tb/sim_dp_ratio_ram.sv
`timescale 1ns/1ps

// One width pair with its own behavioural bit-level model.
module sim_lane #(
  parameter int WA = 1,
  parameter int WB = 1,
  parameter int MA = 0,
  parameter int MB = 0
) (
  input  logic clk,
  input  logic rst,
  output int   errs,
  output int   checks,
  output logic done
);
  localparam int DWA  = (WA >= 9) ? (WA / 9) * 8 : WA;
  localparam int DWB  = (WB >= 9) ? (WB / 9) * 8 : WB;
  localparam int PWA  = WA / 9;
  localparam int PWB  = WB / 9;
  localparam int PPWA = (PWA > 0) ? PWA : 1;
  localparam int PPWB = (PWB > 0) ? PWB : 1;
  localparam int KA   = $clog2(DWA);
  localparam int KB   = $clog2(DWB);

  logic            a_en, a_we, b_en, b_we;
  logic [13:0]     a_addr, b_addr;
  logic [DWA-1:0]  a_din, a_dout;
  logic [DWB-1:0]  b_din, b_dout;
  logic [PPWA-1:0] a_pin, a_pout;
  logic [PPWB-1:0] b_pin, b_pout;

  dp_ratio_ram #(.WIDTH_A(WA), .WIDTH_B(WB), .MODE_A(MA), .MODE_B(MB)) u0 (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
    .a_dout(a_dout), .a_pout(a_pout),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
    .b_dout(b_dout), .b_pout(b_pout)
  );

  logic [16383:0]  m_d;
  logic [2047:0]   m_p;
  logic [DWA-1:0]  xa_d;
  logic [PPWA-1:0] xa_p;
  logic [DWB-1:0]  xb_d;
  logic [PPWB-1:0] xb_p;
  string           ta, tb;
  logic            ska, skb;

  task automatic cmp(input string tag, input string port,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s port %s widths %0d/%0d modes %0d/%0d: actual=%h expected=%h",
               tag, port, WA, WB, MA, MB, act, exp);
    end
  endtask

  task automatic check_all();
    if (!ska) begin
      cmp(ta, "A data", 32'(a_dout), 32'(xa_d));
      if (PWA > 0) cmp(ta, "A parity", 32'(a_pout), 32'(xa_p));
    end
    if (PWA == 0) cmp("R8", "A parity", 32'(a_pout), 32'd0);
    if (!skb) begin
      cmp(tb, "B data", 32'(b_dout), 32'(xb_d));
      if (PWB > 0) cmp(tb, "B parity", 32'(b_pout), 32'(xb_p));
    end
    if (PWB == 0) cmp("R8", "B parity", 32'(b_pout), 32'd0);
  endtask

  // one clock: check last results, drive new inputs, advance the model
  task automatic step(input bit fill,
                      input logic ae, input logic awe, input int aad,
                      input logic [31:0] ad, input logic [31:0] ap,
                      input logic be, input logic bwe, input int bad,
                      input logic [31:0] bd, input logic [31:0] bp);
    int alo, blo, apb, bpb;
    logic ovl;
    logic [DWA-1:0]  ra;
    logic [PPWA-1:0] rpa;
    logic [DWB-1:0]  rb;
    logic [PPWB-1:0] rpb;
    @(negedge clk);
    check_all();
    aad = aad & 16383;
    bad = bad & 16383;
    alo = (aad >> KA) * DWA;
    blo = (bad >> KB) * DWB;
    apb = (aad >> KA) * PWA;
    bpb = (bad >> KB) * PWB;
    ovl = (alo < blo + DWB) && (blo < alo + DWA);
    if (ae && awe && be && bwe && ovl) bwe = 1'b0;  // keep clear of same-bit writes
    a_en = ae; a_we = awe; a_addr = 14'(aad); a_din = DWA'(ad); a_pin = PPWA'(ap);
    b_en = be; b_we = bwe; b_addr = 14'(bad); b_din = DWB'(bd); b_pin = PPWB'(bp);
    ra = '0; rpa = '0; rb = '0; rpb = '0;
    for (int i = 0; i < DWA; i++) ra[i] = m_d[alo + i];
    for (int i = 0; i < PWA; i++) rpa[i] = m_p[apb + i];
    for (int i = 0; i < DWB; i++) rb[i] = m_d[blo + i];
    for (int i = 0; i < PWB; i++) rpb[i] = m_p[bpb + i];
    ska = fill && ae && awe && (MA == 1);
    skb = fill && be && bwe && (MB == 1);
    if (!ae) ta = "R7";
    else if (!awe) begin
      xa_d = ra; xa_p = rpa;
      ta = (be && bwe && ovl) ? "R3" : "R2/R9";
    end else if (MA == 0) begin
      xa_d = a_din; xa_p = (PWA > 0) ? a_pin : '0; ta = "R4";
    end else if (MA == 1) begin
      xa_d = ra; xa_p = rpa; ta = "R5";
    end else ta = "R6";
    if (!be) tb = "R7";
    else if (!bwe) begin
      xb_d = rb; xb_p = rpb;
      tb = (ae && awe && ovl) ? "R3" : "R2/R9";
    end else if (MB == 0) begin
      xb_d = b_din; xb_p = (PWB > 0) ? b_pin : '0; tb = "R4";
    end else if (MB == 1) begin
      xb_d = rb; xb_p = rpb; tb = "R5";
    end else tb = "R6";
    if (ae && awe) begin
      for (int i = 0; i < DWA; i++) m_d[alo + i] = a_din[i];
      for (int i = 0; i < PWA; i++) m_p[apb + i] = a_pin[i];
    end
    if (be && bwe) begin
      for (int i = 0; i < DWB; i++) m_d[blo + i] = b_din[i];
      for (int i = 0; i < PWB; i++) m_p[bpb + i] = b_pin[i];
    end
  endtask

  function automatic int pick_addr();
    return ($urandom % 8 == 0) ? int'($urandom % 16384) : int'($urandom % 96);
  endfunction

  initial begin
    errs = 0; checks = 0; done = 1'b0;
    a_en = 0; a_we = 0; a_addr = '0; a_din = '0; a_pin = '0;
    b_en = 0; b_we = 0; b_addr = '0; b_din = '0; b_pin = '0;
    m_d = '0; m_p = '0;
    xa_d = '0; xa_p = '0; xb_d = '0; xb_p = '0;
    ta = "R1"; tb = "R1"; ska = 0; skb = 0;
    wait (rst == 1'b0);
    // fill every bit through the wider port so the model is fully known
    if (WA >= WB) begin
      for (int n = 0; n < 16384 / DWA; n++)
        step(1'b1, 1, 1, n << KA, $urandom, $urandom, 0, 0, 0, 0, 0);
    end else begin
      for (int n = 0; n < 16384 / DWB; n++)
        step(1'b1, 0, 0, 0, 0, 0, 1, 1, n << KB, $urandom, $urandom);
    end
    step(1'b0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // mixed traffic, mostly in a small window shared by both ports
    repeat (600) begin
      step(1'b0, ($urandom % 5) != 0, $urandom % 2, pick_addr(), $urandom, $urandom,
           ($urandom % 5) != 0, $urandom % 2, pick_addr(), $urandom, $urandom);
    end
    @(negedge clk);
    check_all();
    done = 1'b1;
  end
endmodule

module sim_dp_ratio_ram;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  function automatic int wsel(input int i);
    case (i)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 9;
      default: return 18;
    endcase
  endfunction

  int          l_err [25];
  int          l_chk [25];
  logic [24:0] l_done;

  for (genvar ia = 0; ia < 5; ia++) begin : g_a
    for (genvar ib = 0; ib < 5; ib++) begin : g_b
      sim_lane #(
        .WA(wsel(ia)), .WB(wsel(ib)), .MA((ia + ib) % 3), .MB((ia + 2 * ib) % 3)
      ) u_lane (
        .clk(clk), .rst(rst),
        .errs(l_err[ia*5+ib]), .checks(l_chk[ia*5+ib]), .done(l_done[ia*5+ib])
      );
    end
  end

  initial begin
    int tot_err, tot_chk;
    bit expired;
    expired = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    fork
      wait (&l_done);
      begin
        repeat (60000) @(posedge clk);
        expired = 1'b1;
      end
    join_any
    disable fork;
    tot_err = 0; tot_chk = 0;
    for (int i = 0; i < 25; i++) begin
      tot_err += l_err[i];
      tot_chk += l_chk[i];
    end
    if (expired) begin
      tot_err++; tot_chk++;
      $display("FAIL watchdog: lanes done=%b expected all ones", l_done);
    end
    $display("Result: errors=%0d of %0d checks", tot_err, tot_chk);
    $finish;
  end
endmodule